// File: doc/BRIEF.md
# Recirculating Phase-Capture Reference Demodulator

This block recovers binary data from a hard-limited intermediate-frequency square wave whose polarity is not known in advance. The limited IF bit is sampled into a 12-stage serial shift register on every cycle that carries the sample enable. The enable runs at twelve times the IF rate, so the register holds exactly one IF cycle. While the block waits, the register input is the live IF. The output of the last stage therefore repeats the IF as it was twelve samples earlier.

A capture trigger is pulsed during the message front porch, which is always sent as Mark. The trigger sets a sticky latch. From then on, the register input is taken from its own last stage, so the waveform stored at that moment keeps circulating. It serves as a local reference whose phase stands for Mark. The live IF is XORed with this reference. A majority vote over the most recent XOR samples yields the data bit: 0 for Mark, 1 for Space. Because the reference is learned from the signal itself, an erect or an inverted IF decodes the same way.

Top module: `phase_ref_demod`

## Requirements
- R1: The reference register shifts only on clock edges where `samp_en` is 1. Before capture, `ref_bit` equals the `if_bit` value sampled 12 enabled samples earlier.
- R2: A one-clock `cap_trig` pulse sets `captured` on the following clock. `captured` stays 1 until reset, and any later trigger pulse changes nothing.
- R3: Once `captured` is 1, `ref_bit` repeats the 12 samples held at capture with a period of 12 enabled samples, whatever `if_bit` does.
- R4: After capture, each enabled edge appends `if_bit XOR ref_bit` to a window of the last WIN samples (default 12). On that same edge `data_out` is updated from the window including the new sample. An in-phase IF gives `data_out` = 0 (Mark). An inverted IF gives 1 (Space).
- R5: `data_out` becomes 1 only when more than half of the WIN window samples are 1. With WIN = 12, six ones give 0 and seven give 1.
- R6: While `captured` is 0, `data_out` is 0 whatever the IF does.
- R7: Synchronous active-high `rst` clears the register, the latch, the window and `data_out`, so `ref_bit`, `captured` and `data_out` all read 0.
- R8: Mark is the phase seen at capture. An IF captured inverted and then received in that same inverted phase decodes as 0. The opposite phase decodes as 1.
- R9: Changes of `if_bit` between enabled edges have no effect on `ref_bit`, `captured` or `data_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_en | input | 1 | Sample enable, 12 pulses per IF cycle |
| if_bit | input | 1 | Hard-limited IF comparator bit |
| cap_trig | input | 1 | Capture pulse, given during the Mark front porch |
| data_out | output | 1 | Demodulated data, 0 = Mark, 1 = Space |
| captured | output | 1 | Reference phase has been captured |
| ref_bit | output | 1 | Recirculating reference bit, last register stage |

## Verification
A square wave of period 12 is fed at several phase offsets. Before capture, this shows that the reference is a 12-sample delay of the input while the data stays at Mark. After capture, the input is switched between in-phase and inverted, and runs of flipped samples are placed so that the window count lands exactly on the tie and just past it; this separates the majority threshold from a plain XOR or an off-by-one vote. A constant input after capture separates true recirculation from live sampling. A capture taken on the inverted wave shows that the data polarity follows the captured phase and not a fixed one. Between enables, the input is toggled so that any sampling outside the enable would show up.

// File: rtl/prd_pkg.sv
package prd_pkg;

  // Space decision for the vote window: strictly more than half set.
  function automatic logic vote_space(input int unsigned ones, input int unsigned win);
    return (ones * 2) > win;
  endfunction

  // Width of a counter able to hold 0..n.
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/prd_capture_latch.sv
module prd_capture_latch (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic held,
  output logic set_evt
);

  assign set_evt = trig & ~held;

  always_ff @(posedge clk) begin
    if (rst)          held <= 1'b0;
    else if (set_evt) held <= 1'b1;
  end

  // R2: latch is sticky until reset
  p_latch_sticky_r2: assert property (@(posedge clk) disable iff (rst) held |=> held);
  // R2: a trigger always leaves the latch set on the next clock
  p_trig_sets_r2: assert property (@(posedge clk) disable iff (rst) trig |=> held);

endmodule

// File: rtl/prd_ref_store.sv
module prd_ref_store #(
  parameter int unsigned STAGES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic live_bit,
  input  logic recirc,
  output logic tail_bit,
  output logic feed_bit
);

  logic [STAGES-1:0] sr_q;

  assign tail_bit = sr_q[STAGES-1];
  assign feed_bit = recirc ? tail_bit : live_bit;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (samp_en) sr_q <= feed_bit;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (samp_en) sr_q <= {sr_q[STAGES-2:0], feed_bit};
      end
    end
  endgenerate

  // R1: no shift without the sample enable
  p_shift_gated_r1: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> $stable(sr_q));
  // R1: before capture the head stage takes the live IF
  p_live_entry_r1: assert property (@(posedge clk) disable iff (rst)
    (samp_en && !recirc) |=> sr_q[0] == $past(live_bit));
  // R3: after capture the head stage takes the old tail
  p_recirc_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (samp_en && recirc) |=> sr_q[0] == $past(sr_q[STAGES-1]));

endmodule

// File: rtl/prd_mix_vote.sv
module prd_mix_vote #(
  parameter int unsigned WIN = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic active,
  input  logic live_bit,
  input  logic ref_bit,
  output logic mix_bit,
  output logic data_q
);
  import prd_pkg::*;

  localparam int unsigned CW = count_width(WIN);

  logic [WIN-1:0] win_q, win_nxt;
  logic [CW-1:0]  ones;
  logic           vote;

  assign mix_bit = live_bit ^ ref_bit;

  generate
    if (WIN == 1) begin : g_direct
      assign win_nxt = mix_bit;
    end else begin : g_window
      assign win_nxt = {win_q[WIN-2:0], mix_bit};
    end
  endgenerate

  assign ones = CW'($countones(win_nxt));
  assign vote = vote_space(int'(ones), WIN);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      win_q  <= '0;
      data_q <= 1'b0;
    end else if (samp_en) begin
      win_q  <= win_nxt;
      data_q <= vote;
    end
  end

  // R6: Mark until the reference is captured
  p_mark_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> !data_q);
  // R4: data only moves on an enabled edge
  p_data_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (!samp_en && active) |=> $stable(data_q));
  // R5: an unset new sample cannot turn Mark into Space
  p_no_rise_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (samp_en && active && !mix_bit && !data_q) |=> !data_q);

endmodule

// File: rtl/phase_ref_demod.sv
module phase_ref_demod #(
  parameter int unsigned STAGES = 12,
  parameter int unsigned WIN    = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic if_bit,
  input  logic cap_trig,
  output logic data_out,
  output logic captured,
  output logic ref_bit
);

  logic latch_q;
  logic latch_set_evt;
  logic store_feed;
  logic mix_bit;

  prd_capture_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .trig    (cap_trig),
    .held    (latch_q),
    .set_evt (latch_set_evt)
  );

  prd_ref_store #(.STAGES(STAGES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .live_bit (if_bit),
    .recirc   (latch_q),
    .tail_bit (ref_bit),
    .feed_bit (store_feed)
  );

  prd_mix_vote #(.WIN(WIN)) u_vote (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .active   (latch_q),
    .live_bit (if_bit),
    .ref_bit  (ref_bit),
    .mix_bit  (mix_bit),
    .data_q   (data_out)
  );

  assign captured = latch_q;

  // R7: reset leaves every output at zero
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!captured && !data_out && !ref_bit));
  // R2: a set event is only seen while not yet captured
  p_set_once_r2: assert property (@(posedge clk) disable iff (rst)
    latch_set_evt |-> !captured);
  // R3: once captured the register feeds on itself
  p_feed_src_r3: assert property (@(posedge clk) disable iff (rst)
    captured |-> (store_feed == ref_bit));

endmodule

// File: tb/phase_ref_demod_bench.sv
module phase_ref_demod_bench;

  logic clk = 1'b0;
  logic rst, samp_en, if_bit, cap_trig;
  logic data_out, captured, ref_bit;

  int checks = 0;
  int errors = 0;
  int n = 0;          // enabled samples since reset
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_ref_demod u_phase_ref_demod (
    .clk(clk), .rst(rst), .samp_en(samp_en), .if_bit(if_bit),
    .cap_trig(cap_trig), .data_out(data_out), .captured(captured),
    .ref_bit(ref_bit)
  );

  function automatic logic wave(input int k);
    return ((k % 12) < 6);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  // one enabled sample, with noise on if_bit during the idle clock (R9)
  task automatic step(input logic b);
    @(negedge clk); if_bit = b; samp_en = 1'b1;
    @(negedge clk); samp_en = 1'b0; if_bit = ~b;
    @(negedge clk); if_bit = b;
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; samp_en = 1'b0; cap_trig = 1'b0; if_bit = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    n = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); cap_trig = 1'b1;
    @(negedge clk); cap_trig = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R7", "data_out after reset", data_out, 1'b0);
    check("R7", "captured after reset", captured, 1'b0);
    check("R7", "ref_bit after reset", ref_bit, 1'b0);
  endtask

  task automatic t_precapture();
    do_reset();
    for (int k = 0; k < 24; k++) begin
      step(wave(n + 3));
      if (n >= 12) check("R1", "ref delayed 12 (R9 noise)", ref_bit, wave(n + 3));
      check("R6", "data before capture", data_out, 1'b0);
    end
    for (int k = 0; k < 12; k++) begin
      step(wave(n + 9));
      check("R6", "data before capture, inverted", data_out, 1'b0);
    end
    check("R2", "captured without trigger", captured, 1'b0);
  endtask

  task automatic t_capture_threshold();
    do_reset();
    for (int k = 0; k < 24; k++) step(wave(n));
    pulse_trig();
    check("R2", "captured after trigger", captured, 1'b1);
    for (int k = 0; k < 12; k++) begin
      step(wave(n));
      check("R4", "in-phase gives Mark", data_out, 1'b0);
    end
    for (int k = 0; k < 6; k++) step(wave(n + 6));
    check("R5", "six of twelve is Mark", data_out, 1'b0);
    step(wave(n + 6));
    check("R5", "seven of twelve is Space", data_out, 1'b1);
    for (int k = 0; k < 5; k++) step(wave(n + 6));
    check("R4", "inverted gives Space", data_out, 1'b1);
    for (int k = 0; k < 5; k++) step(wave(n));
    check("R5", "seven ones left stays Space", data_out, 1'b1);
    step(wave(n));
    check("R5", "six ones left returns Mark", data_out, 1'b0);
    for (int k = 0; k < 6; k++) step(wave(n));
    step(~wave(n));
    check("R4", "single flipped sample filtered", data_out, 1'b0);
    for (int k = 0; k < 24; k++) begin
      step(1'b0);
      check("R3", "ref recirculates on idle IF", ref_bit, wave(n));
      if (k == 10) begin
        pulse_trig();
        check("R2", "second trigger keeps captured", captured, 1'b1);
      end
    end
    for (int k = 0; k < 12; k++) step(wave(n + 6));
    check("R2", "second trigger left phase intact", data_out, 1'b1);
    check("R3", "ref phase after inverted input", ref_bit, wave(n));
  endtask

  task automatic t_polarity();
    do_reset();
    for (int k = 0; k < 24; k++) step(wave(n + 6));
    pulse_trig();
    for (int k = 0; k < 12; k++) begin
      step(wave(n + 6));
      check("R8", "captured-phase input is Mark", data_out, 1'b0);
    end
    for (int k = 0; k < 12; k++) step(wave(n));
    check("R8", "opposite phase is Space", data_out, 1'b1);
    do_reset();
    check("R7", "mid-run reset clears captured", captured, 1'b0);
    check("R7", "mid-run reset clears data", data_out, 1'b0);
    check("R7", "mid-run reset clears ref", ref_bit, 1'b0);
  endtask

  initial begin
    rst = 1'b1; samp_en = 1'b0; if_bit = 1'b0; cap_trig = 1'b0;
    t_reset();
    t_precapture();
    t_capture_threshold();
    t_polarity();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule